// File: doc/BRIEF.md
# Switching-Period Hysteresis Enable Controller

This block sits on the secondary side of a flyback supply and decides whether a secondary circuit, such as a synchronous rectifier controller, should run. Each power-cycle detect strobe marks the end of one switching cycle. The block counts clock cycles between strobes and sorts each period into one of three classes: long (above the disable threshold), short (below the enable threshold), or in between. The ratio of the two thresholds is fixed by parameters, so the gap between them gives the hysteresis.

The drive output is active low. After power-up it is released, which means the secondary circuit is enabled. The drive goes low only after an unbroken run of long periods. It is released again after a cumulative number of short periods, and periods that are not short never undo that total. A lockout enable input returns the block to its power-up state while it is low.

Top module: `sw_period_ens_ctrl`

## Requirements
- R1: After reset, `ens_n` is 1, `standby` is 0 (run mode) and both counts are 0.
- R2: A period is the number of clock cycles from one sampled strobe to the next. The first strobe after reset, or after `run_en` returns high, only starts timing. It changes neither count nor the mode.
- R3: In run mode (`standby`=0), a period greater than `LONG_TICKS` adds one to `dis_cnt`.
- R4: In run mode, a period of `LONG_TICKS` or less clears `dis_cnt` to 0.
- R5: The `DIS_COUNT`-th consecutive long period switches the block to standby mode. At the clock edge that samples that strobe, `ens_n` becomes 0, `standby` becomes 1 and both counts become 0.
- R6: In standby mode, a period less than `SHORT_TICKS` adds one to `en_cnt`. Any other period leaves `en_cnt` and the mode unchanged.
- R7: The `EN_COUNT`-th cumulative short period returns the block to run mode. At that edge, `ens_n` becomes 1, `standby` becomes 0 and both counts become 0.
- R8: The period timer saturates at `LONG_TICKS`+1. A gap of any length counts as exactly one long period.
- R9: While `run_en` is 0, the block is held in its power-up state (R1) and strobes are ignored. The next strobe after `run_en` rises only arms the timer (R2).
- R10: `SHORT_TICKS` = `LONG_TICKS`*`RATIO_NUM`/`RATIO_DEN`, rounded down. With `LONG_TICKS`=177 and the default ratio, a period of 56 is short and a period of 57 is not. A period of 177 is not long and a period of 178 is long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Lockout enable; 0 holds the power-up state |
| pcd_stb | input | 1 | One-cycle power-cycle detect strobe |
| ens_n | output | 1 | Secondary enable drive, active low (0 = secondary disabled) |
| dis_cnt | output | DIS_W | Consecutive long-period count |
| en_cnt | output | EN_W | Cumulative short-period count |
| standby | output | 1 | Mode: 0 = run, 1 = standby |

## Verification
The strobe sequences mix runs of long periods broken by one in-between period, which shows that the disable count is consecutive. In standby, short periods are interleaved with in-between and very long periods, which shows that the enable count is cumulative. Periods placed exactly on and one cycle beside each threshold separate strict from non-strict comparison. A very long gap, a strobe right after reset and a pulse on the lockout enable isolate timer saturation and the arm-only first strobe.

// File: rtl/sph_pkg.sv
package sph_pkg;

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_STBY = 1'b1
    } ens_mode_e;

    typedef enum logic [1:0] {
        PER_MID   = 2'd0,
        PER_SHORT = 2'd1,
        PER_LONG  = 2'd2
    } per_class_e;

    function automatic int scale_threshold(input int base, input int num, input int den);
        return (base * num) / den;
    endfunction

endpackage

// File: rtl/sph_period_meter.sv
module sph_period_meter
    import sph_pkg::*;
#(
    parameter int LONG_TICKS  = 177,
    parameter int SHORT_TICKS = 57,
    parameter int TMR_W       = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       pcd_stb,
    output logic       cls_vld,
    output per_class_e cls
);

    localparam logic [TMR_W-1:0] CAP       = TMR_W'(LONG_TICKS + 1);
    localparam logic [TMR_W-1:0] LONG_LIM  = TMR_W'(LONG_TICKS);
    localparam logic [TMR_W-1:0] SHORT_LIM = TMR_W'(SHORT_TICKS);

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic             armed;
    } meter_st_t;

    meter_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        cls_vld = 1'b0;
        cls     = PER_MID;
        if (!run_en) begin
            st_d = '0;
        end else if (pcd_stb) begin
            cls_vld = st_q.armed;
            if (st_q.tmr > LONG_LIM) begin
                cls = PER_LONG;
            end else if (st_q.tmr < SHORT_LIM) begin
                cls = PER_SHORT;
            end
            st_d.armed = 1'b1;
            st_d.tmr   = TMR_W'(1);
        end else if (st_q.tmr != CAP) begin
            st_d.tmr = st_q.tmr + TMR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    tmr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tmr <= CAP);

    // R8
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !pcd_stb && st_q.tmr == CAP) |=> st_q.tmr == CAP);

    // R9
    lockout_noclass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !cls_vld);

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && pcd_stb) |=> (st_q.tmr == TMR_W'(1) && st_q.armed));

endmodule

// File: rtl/sph_hyst_ctrl.sv
module sph_hyst_ctrl
    import sph_pkg::*;
#(
    parameter int DIS_COUNT = 63,
    parameter int EN_COUNT  = 32,
    parameter int DIS_W     = 6,
    parameter int EN_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cls_vld,
    input  per_class_e       cls,
    output ens_mode_e        mode,
    output logic [DIS_W-1:0] dis_cnt,
    output logic [EN_W-1:0]  en_cnt
);

    localparam logic [DIS_W-1:0] DIS_LAST = DIS_W'(DIS_COUNT - 1);
    localparam logic [EN_W-1:0]  EN_LAST  = EN_W'(EN_COUNT - 1);

    typedef struct packed {
        ens_mode_e        mode;
        logic [DIS_W-1:0] dis;
        logic [EN_W-1:0]  en;
    } hyst_st_t;

    hyst_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_en) begin
            st_d.mode = MODE_RUN;
            st_d.dis  = '0;
            st_d.en   = '0;
        end else if (cls_vld) begin
            unique case (st_q.mode)
                MODE_RUN: begin
                    if (cls == PER_LONG) begin
                        if (st_q.dis == DIS_LAST) begin
                            st_d.mode = MODE_STBY;
                            st_d.dis  = '0;
                            st_d.en   = '0;
                        end else begin
                            st_d.dis = st_q.dis + DIS_W'(1);
                        end
                    end else begin
                        st_d.dis = '0;
                    end
                end
                MODE_STBY: begin
                    if (cls == PER_SHORT) begin
                        if (st_q.en == EN_LAST) begin
                            st_d.mode = MODE_RUN;
                            st_d.dis  = '0;
                            st_d.en   = '0;
                        end else begin
                            st_d.en = st_q.en + EN_W'(1);
                        end
                    end
                end
                default: st_d.mode = MODE_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_RUN;
            st_q.dis  <= '0;
            st_q.en   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode    = st_q.mode;
    assign dis_cnt = st_q.dis;
    assign en_cnt  = st_q.en;

    // R5
    enter_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cls_vld && cls == PER_LONG && mode == MODE_RUN && dis_cnt == DIS_LAST)
        |=> (mode == MODE_STBY && dis_cnt == '0 && en_cnt == '0));

    // R7
    leave_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cls_vld && cls == PER_SHORT && mode == MODE_STBY && en_cnt == EN_LAST)
        |=> (mode == MODE_RUN && dis_cnt == '0 && en_cnt == '0));

    // R4
    dis_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cls_vld && cls != PER_LONG && mode == MODE_RUN)
        |=> (mode == MODE_RUN && dis_cnt == '0));

    // R6
    en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cls_vld && cls != PER_SHORT && mode == MODE_STBY)
        |=> (mode == MODE_STBY && $stable(en_cnt)));

    // R3
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !cls_vld) |=> ($stable(mode) && $stable(dis_cnt) && $stable(en_cnt)));

    // R9
    lockout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (mode == MODE_RUN && dis_cnt == '0 && en_cnt == '0));

    // R5
    count_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN) ? (en_cnt == '0) : (dis_cnt == '0));

    // R3
    dis_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_cnt <= DIS_LAST);

endmodule

// File: rtl/sw_period_ens_ctrl.sv
module sw_period_ens_ctrl
    import sph_pkg::*;
#(
    parameter  int LONG_TICKS  = 17700,
    parameter  int RATIO_NUM   = 57,
    parameter  int RATIO_DEN   = 177,
    parameter  int DIS_COUNT   = 63,
    parameter  int EN_COUNT    = 32,
    localparam int SHORT_TICKS = scale_threshold(LONG_TICKS, RATIO_NUM, RATIO_DEN),
    localparam int TMR_W       = $clog2(LONG_TICKS + 2),
    localparam int DIS_W       = (DIS_COUNT > 2) ? $clog2(DIS_COUNT) : 1,
    localparam int EN_W        = (EN_COUNT > 2) ? $clog2(EN_COUNT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             pcd_stb,
    output logic             ens_n,
    output logic [DIS_W-1:0] dis_cnt,
    output logic [EN_W-1:0]  en_cnt,
    output logic             standby
);

    logic       cls_vld;
    per_class_e cls;
    ens_mode_e  mode;

    sph_period_meter #(
        .LONG_TICKS  (LONG_TICKS),
        .SHORT_TICKS (SHORT_TICKS),
        .TMR_W       (TMR_W)
    ) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .pcd_stb (pcd_stb),
        .cls_vld (cls_vld),
        .cls     (cls)
    );

    sph_hyst_ctrl #(
        .DIS_COUNT (DIS_COUNT),
        .EN_COUNT  (EN_COUNT),
        .DIS_W     (DIS_W),
        .EN_W      (EN_W)
    ) u_hyst (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .cls_vld (cls_vld),
        .cls     (cls),
        .mode    (mode),
        .dis_cnt (dis_cnt),
        .en_cnt  (en_cnt)
    );

    assign standby = (mode == MODE_STBY);
    assign ens_n   = (mode == MODE_RUN);

    // R1
    release_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ens_n) |-> $past(cls_vld) && $past(cls) == PER_LONG);

endmodule

// File: tb/tb_sw_period_ens_ctrl.sv
module tb_sw_period_ens_ctrl;

    localparam int LONG_T = 177;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       pcd_stb = 1'b0;
    logic       ens_n;
    logic [5:0] dis_cnt;
    logic [4:0] en_cnt;
    logic       standby;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sw_period_ens_ctrl #(.LONG_TICKS(LONG_T)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .pcd_stb (pcd_stb),
        .ens_n   (ens_n),
        .dis_cnt (dis_cnt),
        .en_cnt  (en_cnt),
        .standby (standby)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input int e_ens, input int e_dis, input int e_en);
        chk({tag, " ens_n"}, int'(ens_n), e_ens);
        chk({tag, " dis_cnt"}, int'(dis_cnt), e_dis);
        chk({tag, " en_cnt"}, int'(en_cnt), e_en);
        chk({tag, " standby"}, int'(standby), 1 - e_ens);
    endtask

    // strobe sampled exactly gap cycles after the previous sampled strobe
    task automatic strobe_gap(input int gap);
        repeat (gap - 1) @(negedge clk);
        pcd_stb = 1'b1;
        @(negedge clk);
        pcd_stb = 1'b0;
    endtask

    localparam int ROWS = 14;
    localparam int GAP[ROWS]   = '{300, 200, 177, 178, 100, 178, 300,  56,  57, 500,  20, 1000, 5, 200};
    localparam int REPS[ROWS]  = '{  1,   5,   1,   3,   1,  62,   1,  10,   5,   3,  21,    1, 1,   1};
    localparam int E_ENS[ROWS] = '{  1,   1,   1,   1,   1,   1,   0,   0,   0,   0,   0,    0, 1,   1};
    localparam int E_DIS[ROWS] = '{  0,   5,   0,   3,   0,  62,   0,   0,   0,   0,   0,    0, 0,   1};
    localparam int E_EN[ROWS]  = '{  0,   0,   0,   0,   0,   0,   0,  10,  10,  10,  31,   31, 0,   0};
    // rows: 0 arm only (R2); 1 long count (R3); 2 boundary 177 clears (R4, R10);
    // 3 boundary 178 long (R10); 4 clear (R4); 5..6 enter standby (R5);
    // 7 short 56 (R6, R10); 8 boundary 57 not short (R10); 9 long in standby (R6);
    // 10..11 cumulative short, long ignored (R6); 12 leave standby (R7); 13 R3 again

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R1 during reset", 1, 0, 0);
        rst_n  = 1'b1;
        run_en = 1'b1;
        @(negedge clk);
        chk_all("R1 after reset", 1, 0, 0);

        for (int r = 0; r < ROWS; r++) begin
            for (int k = 0; k < REPS[r]; k++) strobe_gap(GAP[r]);
            chk_all($sformatf("table row %0d (R2 R3 R4 R5 R6 R7 R10)", r),
                    E_ENS[r], E_DIS[r], E_EN[r]);
        end

        // R8: one very long gap is a single long period
        strobe_gap(20000);
        chk_all("R8 saturated gap", 1, 2, 0);

        // reach standby again: 61 more long periods
        for (int k = 0; k < 60; k++) strobe_gap(180);
        chk_all("R3 before threshold", 1, 62, 0);
        strobe_gap(180);
        chk_all("R5 enter standby", 0, 0, 0);
        for (int k = 0; k < 4; k++) strobe_gap(10);
        chk_all("R6 short in standby", 0, 0, 4);

        // R9: lockout clears everything, strobes ignored
        run_en = 1'b0;
        pcd_stb = 1'b1;
        @(negedge clk);
        pcd_stb = 1'b0;
        repeat (2) @(negedge clk);
        chk_all("R9 lockout", 1, 0, 0);
        run_en = 1'b1;
        strobe_gap(400);
        chk_all("R9 first strobe arms only", 1, 0, 0);
        strobe_gap(5);
        chk_all("R4 short after rearm", 1, 0, 0);
        strobe_gap(200);
        chk_all("R3 long after rearm", 1, 1, 0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule